// File: doc/BRIEF.md
# Time-Interleaved Second-Order MASH Modulator

This block is a digital second-order multi-stage noise-shaping delta-sigma modulator. It is made of two cascaded first-order accumulator stages and a noise-cancelling recombiner. A fractional control word `x_i` is held on the input. On every slow clock the block emits `M` consecutive full-rate output samples side by side. Lane 0 carries the earliest of them. A multiplexer outside the block serialises the lanes into one stream at `M` times the clock rate.

Each stage is an `N`-bit modulo-2^N accumulator. Its carry-out is the stage's one-bit quantiser decision, and its sum is the residue that the next stage takes in. The serial recursion is unrolled across `M` lanes: lane i adds onto lane i-1 of the same slow cycle, and lane 0 adds onto the last lane held from the previous slow cycle. A full slow-cycle register bank sits between the two stages. It holds both the first stage's residues and its carries, so every combinational chain stays inside one accumulator stage. The recombined sample is y[n] = c1[n] + c2[n] - c2[n-1]. It leaves as a 3-bit two's-complement value per lane.

A small fill state machine tracks pipeline fill after a synchronous reset. Its states are FILL0 (reset state, stage 1 has produced nothing), FILL1 (the delay bank holds one slow cycle, the recombiner holds nothing valid), and RUN (outputs valid). Its transitions are FILL0 to FILL1 on the first clock without reset, FILL1 to RUN on the second, RUN to RUN afterwards, and any state to FILL0 on reset.

Top module: `mash_ti_top`

## Requirements
- R1: While `rst` is sampled high on a clock edge, that edge clears every accumulator and delay register. After it, `out_valid_o` is 0 and every lane of `y_o` is 0.
- R2: `out_valid_o` goes to 1 after the second rising edge with `rst` low and stays 1 until the next reset. While it is 0, `y_o` is all zero.
- R3: Lane i of `y_o`, bits [3i+2:3i], equals sample kM+i of a serial MASH 1-1 reference fed with the same per-cycle inputs. Here k counts slow cycles from reset, and lane 0 is the earliest sample. The value is visible two rising edges after the edge that captured the input for slow cycle k.
- R4: Every lane value is one of -1, 0, +1, +2, coded 3'b111, 3'b000, 3'b001, 3'b010.
- R5: An input word of zero held from reset keeps every lane at 0.
- R6: Over S valid samples from reset with a constant input x, the sum of y times 2^N differs from S*x by no more than 2^N in magnitude.
- R7: A change of `x_i` between slow cycles keeps all accumulator state. The outputs continue to match the serial reference driven with the changed input sequence.
- R8: A reset asserted mid-run discards all prior state. Afterwards the output matches a freshly started reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, 1/M of the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | N | Unsigned fractional input word |
| y_o | output | 3*M | M recombined samples, 3-bit two's complement each, lane 0 in the low bits and earliest |
| out_valid_o | output | 1 | High once the pipeline has filled |

## Verification
The bound checker watches four properties on every cycle: the outputs are cleared after reset, the fill timing of `out_valid_o`, the outputs stay silent while not valid, and every lane stays inside the four legal codes. Whether each lane is bit-exact against a serial cascade cannot be expressed as a short property. The same holds for the carry across slow-cycle boundaries, the correct lane order and the long-run mean of the output. The bench shows these by running a serial reference model next to the block under several constant inputs, an input change mid-run and a reset mid-run.

// File: rtl/mash_ti_pkg.sv
package mash_ti_pkg;
    localparam int YW = 3;
    typedef logic signed [YW-1:0] ysamp_t;
    typedef enum logic [1:0] {
        FILL0 = 2'd0,
        FILL1 = 2'd1,
        RUN   = 2'd2
    } fill_state_t;
endpackage

// File: rtl/mash_acc_lanes.sv
// One first-order stage, unrolled over M lanes. The lane chain is combinational
// inside this stage only; the last lane's sum is the carried state.
module mash_acc_lanes #(
    parameter int N = 16,
    parameter int M = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M*N-1:0] addend,
    output logic [M*N-1:0] sum_o,
    output logic [M-1:0]   carry_o
);
    logic [N-1:0] last_q;
    logic [N:0]   part [M];

    generate
        for (genvar i = 0; i < M; i++) begin : g_lane
            if (i == 0) begin : g_first
                assign part[i] = {1'b0, last_q} + {1'b0, addend[N-1:0]};
            end else begin : g_next
                assign part[i] = {1'b0, part[i-1][N-1:0]} + {1'b0, addend[i*N +: N]};
            end
            assign sum_o[i*N +: N] = part[i][N-1:0];
            assign carry_o[i]      = part[i][N];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= part[M-1][N-1:0];
    end
endmodule

// File: rtl/mash_recomb.sv
// Noise-cancelling recombination: y = c1 + c2 - c2 of the previous sample.
module mash_recomb #(
    parameter int M = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [M-1:0]                c1_dly,
    input  logic [M-1:0]                c2,
    output logic [mash_ti_pkg::YW*M-1:0] y_o
);
    import mash_ti_pkg::*;

    logic                c2_tail_q;
    logic [M-1:0]        c2_prev;
    logic [YW*M-1:0]     y_next;

    generate
        for (genvar i = 0; i < M; i++) begin : g_rc
            if (i == 0) begin : g_wrap
                assign c2_prev[i] = c2_tail_q;
            end else begin : g_in
                assign c2_prev[i] = c2[i-1];
            end
            assign y_next[YW*i +: YW] = {{(YW-1){1'b0}}, c1_dly[i]}
                                      + {{(YW-1){1'b0}}, c2[i]}
                                      - {{(YW-1){1'b0}}, c2_prev[i]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            c2_tail_q <= 1'b0;
            y_o       <= '0;
        end else begin
            c2_tail_q <= c2[M-1];
            y_o       <= y_next;
        end
    end
endmodule

// File: rtl/mash_fill_fsm.sv
module mash_fill_fsm (
    input  logic clk,
    input  logic rst,
    output logic out_valid
);
    import mash_ti_pkg::*;

    fill_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL0:   state_d = FILL1;
            FILL1:   state_d = RUN;
            RUN:     state_d = RUN;
            default: state_d = FILL0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FILL0;
        else     state_q <= state_d;
    end

    always_comb begin
        out_valid = (state_q == RUN);
    end
endmodule

// File: rtl/mash_ti_top.sv
module mash_ti_top #(
    parameter int N = 16,
    parameter int M = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N-1:0]                  x_i,
    output logic [mash_ti_pkg::YW*M-1:0]  y_o,
    output logic                          out_valid_o
);
    logic [M*N-1:0] s1_sum;
    logic [M-1:0]   s1_carry;
    logic [M*N-1:0] res_q;
    logic [M-1:0]   c1_q;
    logic [M*N-1:0] s2_sum;
    logic [M-1:0]   s2_carry;

    mash_acc_lanes #(.N(N), .M(M)) u_stage1 (
        .clk     (clk),
        .rst     (rst),
        .addend  ({M{x_i}}),
        .sum_o   (s1_sum),
        .carry_o (s1_carry)
    );

    // Inter-stage register bank: one full slow cycle for residues and carries.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            c1_q  <= '0;
        end else begin
            res_q <= s1_sum;
            c1_q  <= s1_carry;
        end
    end

    mash_acc_lanes #(.N(N), .M(M)) u_stage2 (
        .clk     (clk),
        .rst     (rst),
        .addend  (res_q),
        .sum_o   (s2_sum),
        .carry_o (s2_carry)
    );

    mash_recomb #(.M(M)) u_recomb (
        .clk    (clk),
        .rst    (rst),
        .c1_dly (c1_q),
        .c2     (s2_carry),
        .y_o    (y_o)
    );

    mash_fill_fsm u_fill (
        .clk       (clk),
        .rst       (rst),
        .out_valid (out_valid_o)
    );
endmodule

// File: rtl/mash_ti_chk.sv
module mash_ti_chk #(
    parameter int N = 16,
    parameter int M = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic [mash_ti_pkg::YW*M-1:0]  y_o,
    input logic                          out_valid_o
);
    import mash_ti_pkg::*;

    logic [1:0] since_q;
    logic       bad_code;

    always_ff @(posedge clk) begin
        if (rst)                 since_q <= 2'd0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    always_comb begin
        bad_code = 1'b0;
        for (int i = 0; i < M; i++) begin
            if (y_o[YW*i +: YW] == 3'b011 || y_o[YW*i +: YW] == 3'b100 ||
                y_o[YW*i +: YW] == 3'b101 || y_o[YW*i +: YW] == 3'b110)
                bad_code = 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid_o && y_o == '0));

    p_fill_timing_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid_o == (since_q >= 2'd2));

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> (y_o == '0));

    p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
        !bad_code);

    // Real width is N; reference it so the parameter is used.
    initial begin
        if (N < 1) $display("mash_ti_chk: N must be positive");
    end
endmodule

bind mash_ti_top mash_ti_chk #(.N(N), .M(M)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .y_o         (y_o),
    .out_valid_o (out_valid_o)
);

// File: tb/tb_mash_ti_top.sv
module tb_mash_ti_top;
    localparam int N  = 16;
    localparam int M  = 4;
    localparam int YW = 3;
    localparam int NV = 6;
    localparam longint MOD = 64'd1 << N;
    // {input word, slow cycles}
    localparam logic [31:0] VECS [NV] = '{
        {16'h0000, 16'd150},
        {16'h0001, 16'd200},
        {16'h8000, 16'd150},
        {16'hFFFF, 16'd200},
        {16'h1234, 16'd250},
        {16'h5555, 16'd250}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    x   = '0;
    logic [YW*M-1:0] y;
    logic            v;

    int     total = 0;
    int     bad   = 0;
    int     since = 0;
    longint m_a1, m_a2;
    int     m_c2p;
    int     held [M];
    longint ysum, nsamp;

    always #2 clk = ~clk;

    mash_ti_top #(.N(N), .M(M)) dut (
        .clk(clk), .rst(rst), .x_i(x), .y_o(y), .out_valid_o(v)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane(input int i);
        logic signed [YW-1:0] s;
        s = y[YW*i +: YW];
        return int'(s);
    endfunction

    task automatic model_reset();
        m_a1 = 0; m_a2 = 0; m_c2p = 0;
        ysum = 0; nsamp = 0; since = 0;
    endtask

    task automatic model_cycle(input logic [N-1:0] xv);
        for (int i = 0; i < M; i++) begin
            longint t;
            int c1, c2;
            t = m_a1 + longint'(xv);
            c1 = int'(t / MOD); m_a1 = t % MOD;
            t = m_a2 + m_a1;
            c2 = int'(t / MOD); m_a2 = t % MOD;
            held[i] = c1 + c2 - m_c2p;
            m_c2p = c2;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(v == 1'b0, "R1 valid", longint'(v), 0);
        chk(y == '0, "R1 y", longint'(y), 0);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic run(input logic [N-1:0] xv, input int n, input string req);
        for (int c = 0; c < n; c++) begin
            x = xv;
            @(posedge clk); #1;
            since++;
            chk(v == (since >= 2), "R2 valid timing", longint'(v), longint'(since >= 2));
            if (v) begin
                for (int i = 0; i < M; i++) begin
                    int l;
                    l = lane(i);
                    chk(l == held[i], req, l, held[i]);
                    chk(l >= -1 && l <= 2, "R4 range", l, 0);
                    if (xv == '0) chk(l == 0, "R5 zero input", l, 0);
                    ysum += l;
                    nsamp++;
                end
            end else begin
                chk(y == '0, "R2 quiet fill", longint'(y), 0);
            end
            model_cycle(xv);
        end
    endtask

    initial begin
        #(4 * 190000);
        bad++; total++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Table walk: bit-true lanes (R3) and long-run mean (R6)
        for (int k = 0; k < NV; k++) begin
            logic [N-1:0] xv;
            longint diff;
            xv = VECS[k][31:16];
            do_reset();
            run(xv, int'(VECS[k][15:0]), "R3 lane vs serial");
            diff = ysum * MOD - nsamp * longint'(xv);
            chk(diff >= -MOD && diff <= MOD, "R6 mean", ysum * MOD, nsamp * longint'(xv));
        end

        // R7: input changes keep state
        do_reset();
        run(16'h4000, 10, "R7 before change");
        run(16'hC001, 20, "R7 after change");
        run(16'h0001, 8,  "R7 second change");

        // R8: reset mid-run restarts cleanly
        do_reset();
        run(16'h7777, 7, "R8 pre reset");
        rst = 1'b1;
        @(posedge clk); #1;
        chk(v == 1'b0, "R8 valid cleared", longint'(v), 0);
        chk(y == '0, "R8 y cleared", longint'(y), 0);
        rst = 1'b0;
        model_reset();
        run(16'h7777, 12, "R8 fresh start");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule